// File: doc/BRIEF.md
# Capture/Match Timer Counter

A 32-bit up-counter paced by a 32-bit prescaler, with four compare channels and four snapshot channels. Software programs a prescale value and enables counting. The counter then advances once for every prescale-value-plus-one clock cycles. A pause input freezes counting, and a counter-reset control bit holds everything at zero.

Each compare channel watches for the counter to equal its 32-bit compare value on a prescaler wrap. On such a hit it can restart the count from zero, halt the counter, or just flag the event. Each snapshot channel synchronises an external input through two flops. On a selected rising and/or falling edge it copies the current count into its snapshot register.

Every hit and snapshot sets a status bit, which software clears by writing 1 to it. The interrupt output is the OR of the status bits whose interrupt enables are set. The register port is a simple write strobe with a combinational read.

Top module: `tmr_capmatch_top`

## Requirements
- R1: After reset every register reads zero and `irq` is low. Addresses: 0 control (bit0 count enable, bit1 counter reset), 1 prescale, 2 count (read only), 4 compare control, 5 snapshot control, 6 status, 8+c compare value c, 12+c snapshot value c.
- R2: While enabled and neither paused nor held in reset, the count advances by exactly one every prescale+1 clock cycles.
- R3: While control bit1 is set, the count and the prescaler are held at zero.
- R4: While `pause` is high, the count and the prescaler do not change.
- R5: A compare hit on channel c sets status bit c. Compare control bit 3c enables the interrupt for channel c. `irq` stays low for a set status bit whose enable is clear.
- R6: With compare control bit 3c+1 set, the count holds the compare value for one prescaled period and then returns to zero on the next wrap.
- R7: With compare control bit 3c+2 set, a hit clears control bit0 and the count stays at the compare value. If software writes control in the same cycle, the clear takes priority.
- R8: Snapshot control bits 3c and 3c+1 enable capture on rising and falling edges of `cap_in[c]`. An edge is loaded into snapshot register c on the third rising clock edge after the input changes. A disabled edge direction captures nothing.
- R9: A snapshot on channel c sets status bit 4+c. Snapshot control bit 3c+2 gates it onto `irq`.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle as the clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pause | input | 1 | Freezes counter and prescaler while high |
| cap_in | input | 4 | Asynchronous snapshot trigger inputs |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | OR of enabled status bits |

## Verification
A hardware event and a software write-1-to-clear of the same status bit can land in the same cycle. The bench provokes this with a snapshot edge, whose latency of three clock edges after the input change is fixed. It times the status-clear write so that the write and the snapshot fall on the same edge. The bench then expects the status bit to read 1 and the snapshot register to hold the count at that edge. A separate write, with no event pending, must clear the bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRESC = 4'd1;
  localparam logic [ADDR_W-1:0] A_COUNT = 4'd2;
  localparam logic [ADDR_W-1:0] A_MCTL  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CCTL  = 4'd5;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd6;
  localparam int MATCH_BASE = 8;
  localparam int SNAP_BASE  = 12;
  localparam int FIELD_W    = 3;
endpackage

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          crst,
  input  logic          pause,
  input  logic [TW-1:0] presc,
  input  logic          mreset,
  input  logic          mstop,
  output logic [TW-1:0] count,
  output logic          tick
);
  logic [TW-1:0] pcnt_q, pcnt_d, cnt_q, cnt_d;
  logic          running;

  always_comb begin
    running = en & ~crst & ~pause;
    tick    = running && (pcnt_q >= presc);
    pcnt_d  = pcnt_q;
    cnt_d   = cnt_q;
    if (crst) begin
      pcnt_d = '0;
      cnt_d  = '0;
    end else if (running) begin
      pcnt_d = tick ? '0 : pcnt_q + 1'b1;
      if (tick) begin
        if (mreset)     cnt_d = '0;
        else if (!mstop) cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign count = cnt_q;

  assert_crst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    crst |=> (cnt_q == '0 && pcnt_q == '0));
  assert_pause_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !crst) |=> ($stable(cnt_q) && $stable(pcnt_q)));
  assert_match_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mreset) |=> (cnt_q == '0));
  assert_stop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mstop && !mreset) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit #(
  parameter int TW = 32,
  parameter int NM = 4
) (
  input  logic                  tick,
  input  logic [TW-1:0]         count,
  input  logic [NM-1:0][TW-1:0] mval,
  input  logic [3*NM-1:0]       mctl,
  output logic [NM-1:0]         hit,
  output logic                  mreset,
  output logic                  mstop
);
  logic [NM-1:0] rs_sel, st_sel;

  for (genvar i = 0; i < NM; i++) begin : g_cmp
    assign hit[i]    = tick && (count == mval[i]);
    assign rs_sel[i] = mctl[3*i+1];
    assign st_sel[i] = mctl[3*i+2];
  end

  assign mreset = |(hit & rs_sel);
  assign mstop  = |(hit & st_sel);
endmodule

// File: rtl/tmr_snap_chan.sv
module tmr_snap_chan #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic          rise_en,
  input  logic          fall_en,
  input  logic [TW-1:0] count,
  output logic          evt,
  output logic [TW-1:0] snap
);
  logic s1_q, s2_q, s3_q;
  logic [TW-1:0] snap_q, snap_d;

  always_comb begin
    evt    = (rise_en && s2_q && !s3_q) || (fall_en && !s2_q && s3_q);
    snap_d = evt ? count : snap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      snap_q <= '0;
    end else begin
      s1_q   <= pin;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      snap_q <= snap_d;
    end
  end

  assign snap = snap_q;

  assert_snap_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (snap_q == $past(count)));
  assert_snap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(snap_q));
endmodule

// File: rtl/tmr_capmatch_top.sv
module tmr_capmatch_top
  import tmr_pkg::*;
#(
  parameter int TW = 32,
  parameter int NM = 4,
  parameter int NC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pause,
  input  logic [NC-1:0]     cap_in,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TW-1:0]     wdata,
  output logic [TW-1:0]     rdata,
  output logic              irq
);
  localparam int NS = NM + NC;

  logic rs1_q, rs2_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  logic [1:0]              ctrl_q, ctrl_d;
  logic [TW-1:0]           presc_q, presc_d;
  logic [3*NM-1:0]         mctl_q, mctl_d;
  logic [3*NC-1:0]         cctl_q, cctl_d;
  logic [NS-1:0]           stat_q, stat_d, irq_mask;
  logic [NM-1:0][TW-1:0]   mval_q, mval_d;
  logic [NC-1:0][TW-1:0]   snap;
  logic [NC-1:0]           cevt;
  logic [NM-1:0]           hit;
  logic [TW-1:0]           count;
  logic                    tick, mreset, mstop;

  tmr_count_core #(.TW(TW)) u_core (
    .clk(clk), .rst_n(srst_n), .en(ctrl_q[0]), .crst(ctrl_q[1]), .pause(pause),
    .presc(presc_q), .mreset(mreset), .mstop(mstop), .count(count), .tick(tick));

  tmr_match_unit #(.TW(TW), .NM(NM)) u_match (
    .tick(tick), .count(count), .mval(mval_q), .mctl(mctl_q),
    .hit(hit), .mreset(mreset), .mstop(mstop));

  for (genvar c = 0; c < NC; c++) begin : g_snap
    tmr_snap_chan #(.TW(TW)) u_snap (
      .clk(clk), .rst_n(srst_n), .pin(cap_in[c]),
      .rise_en(cctl_q[3*c]), .fall_en(cctl_q[3*c+1]),
      .count(count), .evt(cevt[c]), .snap(snap[c]));
    assign irq_mask[NM+c] = cctl_q[3*c+2];
  end
  for (genvar m = 0; m < NM; m++) begin : g_mmask
    assign irq_mask[m] = mctl_q[3*m];
  end

  always_comb begin
    ctrl_d  = ctrl_q;
    presc_d = presc_q;
    mctl_d  = mctl_q;
    cctl_d  = cctl_q;
    mval_d  = mval_q;
    stat_d  = stat_q;
    if (we) begin
      if (addr == A_CTRL)  ctrl_d  = wdata[1:0];
      if (addr == A_PRESC) presc_d = wdata;
      if (addr == A_MCTL)  mctl_d  = wdata[3*NM-1:0];
      if (addr == A_CCTL)  cctl_d  = wdata[3*NC-1:0];
      if (addr == A_STAT)  stat_d  = stat_q & ~wdata[NS-1:0];
      for (int m = 0; m < NM; m++)
        if (int'(addr) == MATCH_BASE + m) mval_d[m] = wdata;
    end
    if (mstop) ctrl_d[0] = 1'b0;
    stat_d = stat_d | {cevt, hit};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      mctl_q  <= '0;
      cctl_q  <= '0;
      mval_q  <= '0;
      stat_q  <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      presc_q <= presc_d;
      mctl_q  <= mctl_d;
      cctl_q  <= cctl_d;
      mval_q  <= mval_d;
      stat_q  <= stat_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[1:0]      = ctrl_q;
      A_PRESC: rdata           = presc_q;
      A_COUNT: rdata           = count;
      A_MCTL:  rdata[3*NM-1:0] = mctl_q;
      A_CCTL:  rdata[3*NC-1:0] = cctl_q;
      A_STAT:  rdata[NS-1:0]   = stat_q;
      default: ;
    endcase
    for (int m = 0; m < NM; m++)
      if (int'(addr) == MATCH_BASE + m) rdata = mval_q[m];
    for (int c = 0; c < NC; c++)
      if (int'(addr) == SNAP_BASE + c) rdata = snap[c];
  end

  assign irq = |(stat_q & irq_mask);

  for (genvar m = 0; m < NM; m++) begin : g_mchk
    assert_hit_flag_R5: assert property (@(posedge clk) disable iff (!srst_n)
      hit[m] |=> stat_q[m]);
    assert_stop_clear_R7: assert property (@(posedge clk) disable iff (!srst_n)
      (hit[m] && mctl_q[3*m+2]) |=> !ctrl_q[0]);
  end
  for (genvar c = 0; c < NC; c++) begin : g_cchk
    assert_snap_flag_R9: assert property (@(posedge clk) disable iff (!srst_n)
      cevt[c] |=> stat_q[NM+c]);
  end
  assert_stat_sticky_R10: assert property (@(posedge clk) disable iff (!srst_n)
    !(we && addr == A_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: tb/test_tmr_capmatch_top.sv
module test_tmr_capmatch_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pause;
  logic [3:0]  cap_in;
  logic        we;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_capmatch_top i_tmr_capmatch_top (
    .clk(clk), .rst_n(rst_n), .pause(pause), .cap_in(cap_in), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset_state;
    logic [31:0] v;
    rd(4'd0, v);  chk(v == 0, "R1 control", v, 0);
    rd(4'd2, v);  chk(v == 0, "R1 count", v, 0);
    rd(4'd6, v);  chk(v == 0, "R1 status", v, 0);
    rd(4'd12, v); chk(v == 0, "R1 snapshot0", v, 0);
    chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_prescale;
    logic [31:0] a, b;
    wr(4'd1, 32'd3);
    wr(4'd0, 32'd1);
    rd(4'd2, a);
    waitn(40);
    rd(4'd2, b);
    chk(b - a == 32'd10, "R2 rate prescale 3", b - a, 10);
  endtask

  task automatic t_crst;
    logic [31:0] v;
    wr(4'd0, 32'd3);
    waitn(5);
    rd(4'd2, v);
    chk(v == 0, "R3 held at zero", v, 0);
  endtask

  task automatic t_pause;
    logic [31:0] v;
    wr(4'd1, 32'd0);
    pause = 1'b1;
    wr(4'd0, 32'd1);
    waitn(10);
    rd(4'd2, v);
    chk(v == 0, "R4 frozen while paused", v, 0);
    pause = 1'b0;
    waitn(10);
    rd(4'd2, v);
    chk(v == 10, "R2 R4 resumes one per cycle", v, 10);
  endtask

  task automatic t_reset_on_match;
    logic [31:0] v, mx;
    int zeros;
    wr(4'd0, 32'd3);
    wr(4'd8, 32'd5);
    wr(4'd4, 32'b011);
    wr(4'd6, 32'hFF);
    wr(4'd0, 32'd1);
    mx = 0; zeros = 0;
    for (int k = 0; k < 30; k++) begin
      rd(4'd2, v);
      if (v > mx) mx = v;
      if (v == 0) zeros++;
      @(negedge clk);
    end
    chk(mx == 5, "R6 peak equals compare value", mx, 5);
    chk(zeros >= 3, "R6 returns to zero repeatedly", zeros, 3);
    rd(4'd6, v);
    chk(v[0] == 1'b1, "R5 status bit0", v, 1);
    chk(irq == 1'b1, "R5 irq enabled", {31'b0, irq}, 1);
  endtask

  task automatic t_stop_on_match;
    logic [31:0] v;
    wr(4'd0, 32'd3);
    wr(4'd4, 32'd1 << 5);
    wr(4'd9, 32'd7);
    wr(4'd6, 32'hFF);
    wr(4'd0, 32'd1);
    waitn(30);
    rd(4'd2, v); chk(v == 7, "R7 count stays at compare", v, 7);
    rd(4'd0, v); chk(v == 0, "R7 enable cleared", v, 0);
    rd(4'd6, v); chk(v[1] == 1'b1, "R5 status bit1", v, 2);
    chk(irq == 1'b0, "R5 irq masked", {31'b0, irq}, 0);
  endtask

  task automatic t_snapshots;
    logic [31:0] v;
    wr(4'd5, 32'd1 << 6);
    wr(4'd6, 32'hFF);
    cap_in[2] = 1'b1;
    waitn(2);
    rd(4'd14, v); chk(v == 0, "R8 not yet after two edges", v, 0);
    waitn(1);
    rd(4'd14, v); chk(v == 7, "R8 rising capture on third edge", v, 7);
    rd(4'd6, v);  chk(v[6] == 1'b1, "R9 snapshot status bit6", v, 32'h40);
    chk(irq == 1'b0, "R9 snapshot irq masked", {31'b0, irq}, 0);
    wr(4'd5, (32'd1 << 6) | (32'h7 << 9));
    cap_in[3] = 1'b1;
    waitn(5);
    rd(4'd15, v); chk(v == 7, "R8 both-edge channel rising", v, 7);
    rd(4'd6, v);  chk(v[7] == 1'b1, "R9 status bit7", v, 32'h80);
    chk(irq == 1'b1, "R9 snapshot irq enabled", {31'b0, irq}, 1);
    wr(4'd0, 32'd2);
    wr(4'd0, 32'd0);
    wr(4'd6, 32'hFF);
    cap_in[2] = 1'b0;
    waitn(5);
    rd(4'd14, v); chk(v == 7, "R8 falling ignored on rise-only", v, 7);
    rd(4'd6, v);  chk(v == 0, "R8 no status on ignored edge", v, 0);
  endtask

  task automatic t_collision;
    logic [31:0] v;
    @(negedge clk);
    cap_in[3] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = 4'd6; wdata = 32'h80;
    @(negedge clk);
    we = 1'b0;
    rd(4'd6, v);  chk(v[7] == 1'b1, "R10 event wins over clear", v, 32'h80);
    rd(4'd15, v); chk(v == 0, "R8 falling capture on both-edge", v, 0);
    wr(4'd6, 32'h0);
    rd(4'd6, v);  chk(v[7] == 1'b1, "R10 write zero keeps bit", v, 32'h80);
    wr(4'd6, 32'h80);
    rd(4'd6, v);  chk(v == 0, "R10 write one clears", v, 0);
    chk(irq == 1'b0, "R10 irq drops after clear", {31'b0, irq}, 0);
  endtask

  initial begin
    rst_n = 1'b0; pause = 1'b0; cap_in = '0; we = 1'b0; addr = '0; wdata = '0;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);
    t_reset_state();
    t_prescale();
    t_crst();
    t_pause();
    t_reset_on_match();
    t_stop_on_match();
    t_snapshots();
    t_collision();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule